// File: doc/BRIEF.md
# Oversampling Serial Receiver with Per-Word Error Flags

This block recovers asynchronous NRZ frames from a single serial line. A pulse on `sample_tick` arrives sixteen times per bit period; on those pulses the receiver hunts for a start bit and confirms it at mid-bit. It then decides each data bit by a three-sample vote and checks the stop bit. Frames carry eight data bits, least significant first, or nine when `nine_bit_mode` is set. Finished words go into a two-entry queue together with their ninth bit and a framing-error flag. The receiving logic reads the oldest entry from the output ports and pops it with `read_strobe`.

If a word completes while the queue is full, the word is dropped and `overrun` latches. Reception then stays frozen until `rx_enable` is dropped and raised again. Dropping `rx_enable` also empties the queue and abandons any frame in progress.

Top module: `rxo_receiver`

## Requirements
- R1: Frames are received only while `rx_enable` is 1; a frame sent while it is 0 leaves `word_avail` at 0.
- R2: In idle, a tick that sees the line low is tick 0 of a start bit. The start bit is accepted only if the line is still low at tick 8; otherwise the receiver returns to idle and stores nothing.
- R3: Each bit slot spans 16 ticks counted from the start edge. Its value is the majority of the line samples at ticks 7, 8 and 9 of the slot, so a single disagreeing sample among those three does not change the result. Data bits arrive least significant first.
- R4: With `nine_bit_mode` = 0 a frame has 8 data bits and `word_bit9` reads 0. With `nine_bit_mode` = 1 a ninth data bit follows bit 7 and is reported on `word_bit9`.
- R5: A completed word enters a two-entry queue. The ports `word_data`, `word_bit9` and `word_ferr` always show the oldest stored word, and words leave in arrival order.
- R6: `word_avail` is 1 while the queue holds at least one word. A `read_strobe` cycle removes the oldest word. `word_avail` returns to 0 once the queue is emptied, and a strobe on an empty queue changes nothing.
- R7: `word_ferr` is 1 for a word whose stop-bit vote is low. The flag is stored with that word only and is not carried to later words.
- R8: A word that completes while two words are stored, with no read in that cycle, is discarded and sets `overrun`.
- R9: While `overrun` is 1 no word enters the queue, although stored words can still be read. `overrun` stays set until `rx_enable` is 0.
- R10: Setting `rx_enable` to 0 empties the queue, clears `overrun` and aborts a frame in progress within one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Serial line, idle high |
| sample_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_enable | input | 1 | Continuous receive enable; low resets the receive logic |
| nine_bit_mode | input | 1 | 1 selects nine data bits per frame |
| read_strobe | input | 1 | Pops the oldest stored word |
| word_data | output | 8 | Low eight bits of the oldest word |
| word_bit9 | output | 1 | Ninth bit of the oldest word |
| word_ferr | output | 1 | Framing error of the oldest word |
| overrun | output | 1 | Sticky overrun flag |
| word_avail | output | 1 | Queue not empty |

## Verification
On every cycle the assertions check the following. The queue is never written beyond its depth. A pop of an empty queue leaves it empty. `overrun` stays set while enabled, and the queue does not grow while it is set. Disabling clears both queue and overrun. The completion pulse is never longer than one clock. Only the bench scenarios can show that bits are recovered correctly, which covers the whole 8-bit value space, nine-bit words, votes with one corrupted sample, and start pulses too short to be accepted. The bench scenarios also show that each word keeps its own framing flag through the queue, and that words sent during overrun or while disabled are really lost.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP
    } rx_state_t;

    typedef struct packed {
        logic              ferr;
        logic              bit9;
        logic [DATA_W-1:0] data;
    } rx_word_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rxo_sampler.sv
module rxo_sampler
    import rxo_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     line,
    input  logic     tick,
    input  logic     nine,
    output logic     done,
    output rx_word_t word
);
    localparam int TW  = $clog2(OVS);
    localparam int MID = OVS / 2;
    localparam int BW  = $clog2(DATA_W + 1);

    rx_state_t       st;
    logic [TW-1:0]   tcnt;
    logic [BW-1:0]   bidx;
    logic [DATA_W:0] shreg;
    logic            s_a, s_b;
    logic [BW-1:0]   last_idx;
    logic [TW-1:0]   tnext;

    assign last_idx = nine ? BW'(DATA_W) : BW'(DATA_W - 1);
    assign tnext    = (tcnt == TW'(OVS - 1)) ? '0 : tcnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            st    <= S_IDLE;
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
            s_a   <= 1'b1;
            s_b   <= 1'b1;
            done  <= 1'b0;
            word  <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (tcnt == TW'(MID - 1)) s_a <= line;
                if (tcnt == TW'(MID))     s_b <= line;
                case (st)
                    S_IDLE: begin
                        if (!line) begin
                            st   <= S_START;
                            tcnt <= TW'(1);
                        end
                    end
                    S_START: begin
                        if (tcnt == TW'(MID) && line) begin
                            st   <= S_IDLE;
                            tcnt <= '0;
                        end else begin
                            tcnt <= tnext;
                            if (tcnt == TW'(OVS - 1)) begin
                                st   <= S_DATA;
                                bidx <= '0;
                            end
                        end
                    end
                    S_DATA: begin
                        tcnt <= tnext;
                        if (tcnt == TW'(MID + 1))
                            shreg[bidx] <= vote3(s_a, s_b, line);
                        if (tcnt == TW'(OVS - 1)) begin
                            if (bidx == last_idx) st <= S_STOP;
                            else                  bidx <= bidx + 1'b1;
                        end
                    end
                    S_STOP: begin
                        tcnt <= tnext;
                        if (tcnt == TW'(MID + 1)) begin
                            done      <= 1'b1;
                            word.data <= shreg[DATA_W-1:0];
                            word.bit9 <= nine & shreg[DATA_W];
                            word.ferr <= ~vote3(s_a, s_b, line);
                            st        <= S_IDLE;
                            tcnt      <= '0;
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    assert_single_done_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_disable_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (st == S_IDLE) && !done);

endmodule

// File: rtl/rxo_fifo.sv
module rxo_fifo
    import rxo_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     push,
    input  rx_word_t din,
    input  logic     pop_req,
    output rx_word_t head,
    output logic     full,
    output logic     nonempty,
    output logic     pop_ok
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_word_t      mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] count;

    assign full     = (count == CW'(DEPTH));
    assign nonempty = (count != '0);
    assign pop_ok   = pop_req && nonempty;
    assign head     = mem[rp];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop_ok) rp <= bump(rp);
            count <= count + CW'(push) - CW'(pop_ok);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (push && wp == PW'(i))
                mem[i] <= din;
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (full && push) |-> pop_ok);

    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (rst)
        (!nonempty && pop_req && !push && !flush) |=> !nonempty);

endmodule

// File: rtl/rxo_receiver.sv
module rxo_receiver
    import rxo_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              sample_tick,
    input  logic              rx_enable,
    input  logic              nine_bit_mode,
    input  logic              read_strobe,
    output logic [DATA_W-1:0] word_data,
    output logic              word_bit9,
    output logic              word_ferr,
    output logic              overrun,
    output logic              word_avail
);
    logic     done, full, pop_ok, push;
    rx_word_t word, head;

    rxo_sampler #(.OVS(OVS)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .enable (rx_enable),
        .line   (rx_line),
        .tick   (sample_tick),
        .nine   (nine_bit_mode),
        .done   (done),
        .word   (word)
    );

    assign push = done && !overrun && (!full || pop_ok);

    rxo_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .flush    (!rx_enable),
        .push     (push),
        .din      (word),
        .pop_req  (read_strobe),
        .head     (head),
        .full     (full),
        .nonempty (word_avail),
        .pop_ok   (pop_ok)
    );

    always_ff @(posedge clk) begin
        if (rst || !rx_enable)
            overrun <= 1'b0;
        else if (done && full && !pop_ok)
            overrun <= 1'b1;
    end

    assign word_data = head.data;
    assign word_bit9 = head.bit9;
    assign word_ferr = head.ferr;

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (overrun && rx_enable) |=> overrun);

    assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (overrun && rx_enable && !read_strobe && full) |=> full);

    assert_flush_R10: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> (!word_avail && !overrun));

endmodule

// File: tb/rxo_receiver_bench.sv
`timescale 1ns/1ps
module rxo_receiver_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       sample_tick = 1'b0;
    logic       rx_enable = 1'b0;
    logic       nine_bit_mode = 1'b0;
    logic       read_strobe = 1'b0;
    logic [7:0] word_data;
    logic       word_bit9, word_ferr, overrun, word_avail;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rxo_receiver u_rxo_receiver (
        .clk(clk), .rst(rst), .rx_line(rx_line), .sample_tick(sample_tick),
        .rx_enable(rx_enable), .nine_bit_mode(nine_bit_mode),
        .read_strobe(read_strobe), .word_data(word_data), .word_bit9(word_bit9),
        .word_ferr(word_ferr), .overrun(overrun), .word_avail(word_avail)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic one_tick();
        @(negedge clk) sample_tick = 1'b1;
        @(negedge clk) sample_tick = 1'b0;
    endtask

    task automatic idle_ticks(input int n);
        rx_line = 1'b1;
        for (int i = 0; i < n; i++) one_tick();
    endtask

    // slot 0 = start, 1..nd = data, nd+1 = stop; gslot<0 means no glitch
    task automatic send(input logic [8:0] w, input logic nine, input logic stopv,
                        input int gslot, input int gtick);
        int nd = nine ? 9 : 8;
        for (int s = 0; s <= nd + 1; s++) begin
            logic v = (s == 0) ? 1'b0 : (s == nd + 1) ? stopv : w[s-1];
            for (int t = 0; t < 16; t++) begin
                rx_line = v ^ ((s == gslot) && (t == gtick));
                one_tick();
            end
        end
        idle_ticks(16);
    endtask

    task automatic pop();
        @(negedge clk) read_strobe = 1'b1;
        @(negedge clk) read_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic toggle_enable();
        @(negedge clk) rx_enable = 1'b0;
        @(negedge clk) rx_enable = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R6 reset avail", word_avail, 0);
        check("R9 reset overrun", overrun, 0);

        // R1: disabled receiver ignores a frame
        send(9'h0A5, 1'b0, 1'b1, -1, 0);
        check("R1 disabled no word", word_avail, 0);
        rx_enable = 1'b1;
        idle_ticks(4);

        // R6: read on empty queue changes nothing
        pop();
        check("R6 empty pop avail", word_avail, 0);

        // R2: short start pulse rejected
        rx_line = 1'b0;
        for (int i = 0; i < 3; i++) one_tick();
        idle_ticks(32);
        check("R2 short start rejected", word_avail, 0);

        // R3 R4: sweep all 8-bit values, odd values carry one corrupted vote sample
        for (int v = 0; v < 256; v++) begin
            int gs = (v % 2 == 1) ? (v % 8) + 1 : -1;
            send(9'(v), 1'b0, 1'b1, gs, 7 + (v % 3));
            check("R3 sweep avail", word_avail, 1);
            check("R3 sweep data", word_data, v);
            check("R4 eight-bit bit9 zero", word_bit9, 0);
            check("R7 sweep no ferr", word_ferr, 0);
            pop();
            check("R6 cleared after read", word_avail, 0);
        end

        // R4: nine-bit words
        nine_bit_mode = 1'b1;
        for (int v = 0; v < 12; v++) begin
            logic [8:0] w = 9'((v * 83 + 17) % 512);
            send(w, 1'b1, 1'b1, (v == 3) ? 9 : -1, 8);
            check("R4 nine data", word_data, int'(w[7:0]));
            check("R4 nine bit9", word_bit9, int'(w[8]));
            pop();
        end
        nine_bit_mode = 1'b0;

        // R5 R7: two words, first with framing error, flags travel per word
        send(9'h03C, 1'b0, 1'b0, -1, 0);
        send(9'h0C3, 1'b0, 1'b1, -1, 0);
        check("R5 head first", word_data, 8'h3C);
        check("R7 first ferr", word_ferr, 1);
        pop();
        check("R5 head second", word_data, 8'hC3);
        check("R7 second no ferr", word_ferr, 0);
        check("R6 still avail", word_avail, 1);
        pop();
        check("R6 emptied", word_avail, 0);

        // R8: third word while full is lost
        send(9'h011, 1'b0, 1'b1, -1, 0);
        send(9'h022, 1'b0, 1'b1, -1, 0);
        check("R8 no overrun at two", overrun, 0);
        send(9'h033, 1'b0, 1'b1, -1, 0);
        check("R8 overrun set", overrun, 1);
        check("R8 head kept", word_data, 8'h11);
        pop();
        check("R8 second kept", word_data, 8'h22);
        pop();
        check("R8 third lost", word_avail, 0);

        // R9: frozen while overrun
        send(9'h044, 1'b0, 1'b1, -1, 0);
        check("R9 frozen no word", word_avail, 0);
        check("R9 overrun held", overrun, 1);
        toggle_enable();
        check("R9 overrun cleared", overrun, 0);
        send(9'h055, 1'b0, 1'b1, -1, 0);
        check("R9 receive after clear", word_data, 8'h55);
        check("R9 avail after clear", word_avail, 1);

        // R10: disable flushes the queue
        toggle_enable();
        check("R10 flushed", word_avail, 0);

        // R10: abort a frame midway; following frame still correct
        rx_line = 1'b0;
        for (int i = 0; i < 40; i++) one_tick();
        @(negedge clk) rx_enable = 1'b0;
        idle_ticks(32);
        @(negedge clk) rx_enable = 1'b1;
        check("R10 abort no word", word_avail, 0);
        send(9'h096, 1'b0, 1'b1, -1, 0);
        check("R10 clean frame after abort", word_data, 8'h96);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule